// File: doc/BRIEF.md
# Multibank Serial Page Crossbar

This block is the memory-side datapath of a multibanked DRAM that exposes its banks through narrow serial ports. Every bank owns a page register the width of one data block. The page register doubles as a shift register. A crossbar binds any bank to any serial port. While bound, the bank either streams its page out on that port or collects a new page from it. Transfers on separate ports run side by side, so several whole-block moves can be in flight at once.

A single command channel binds a bank to a port for one transfer. The command carries a bank index, a port index, a page row and a direction. For a read-out, the bank copies the addressed row into its page register in one cycle. It then shifts the page onto the port without a gap. For a write-in, the bank gathers serial beats from the port until the page is full. It then commits the page to the row in parallel and pulses a per-port done flag. A separate parallel host path stores and fetches whole pages. It fills and inspects the bank arrays directly.

Top module: `serial_page_xbar`

## Requirements
- R1: After a synchronous active-high reset, `cmd_ack`, `cmd_err`, every `sout_vld` bit, every `sout_data` bit and every `wr_done` bit are low.
- R2: A read-out command (`cmd_dir`=0) is accepted by a one-cycle `cmd_ack` pulse after the sampling edge. If that edge is n, beat k (k = 0 … PAGE_W/LANE_W−1) is presented after edge n+2+k. Beats come most significant chunk first, LANE_W bits each, with `sout_vld` high for exactly PAGE_W/LANE_W back-to-back cycles.
- R3: In a write-in transfer (`cmd_dir`=1), the port's lane is taken only in cycles where its `sin_vld` bit is high. Chunks arrive most significant first. One edge after the edge that takes the last beat, the page is stored in the addressed row and the port's `wr_done` is high for exactly one cycle.
- R4: A command that names a bank or a port already engaged in a transfer gets a one-cycle `cmd_err` and no `cmd_ack`. It leaves every ongoing transfer unchanged.
- R5: Transfers on different ports, in either direction, proceed at the same time without affecting each other's data or timing.
- R6: While a port has no beat to present, its `sout_vld` bit is low and its `sout_data` lane is zero.
- R7: `pg_wr` stores `pg_wdata` into row `pg_row` of bank `pg_bank` at the sampling edge. `pg_rd` presents that row on `pg_rdata` after the next edge. A read-out accepted on the same edge as a host store to its bank and row streams the newly stored page.
- R8: A host store aimed at a bank that is engaged in a transfer is dropped; all rows of that bank keep their contents.
- R9: Every bank can be bound to every port. A transfer appears only on the port that was named.
- R10: A command whose port index is NPORT or above, or whose row index is ROWS or above, gets `cmd_err` and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Bind request strobe |
| cmd_dir | input | 1 | 0 = read out of bank, 1 = write into bank |
| cmd_bank | input | BANK_W | Bank to bind |
| cmd_port | input | PORT_W | Serial port to bind |
| cmd_row | input | ROW_W | Page row inside the bank |
| cmd_ack | output | 1 | Request accepted (one cycle) |
| cmd_err | output | 1 | Request rejected (one cycle) |
| pg_wr | input | 1 | Host page store strobe |
| pg_rd | input | 1 | Host page fetch strobe |
| pg_bank | input | BANK_W | Host bank index |
| pg_row | input | ROW_W | Host row index |
| pg_wdata | input | PAGE_W | Page to store |
| pg_rdata | output | PAGE_W | Fetched page |
| sin_data | input | NPORT*LANE_W | Serial input lanes, port p at bits p*LANE_W upward |
| sin_vld | input | NPORT | Serial input beat valid per port |
| sout_data | output | NPORT*LANE_W | Serial output lanes, same packing |
| sout_vld | output | NPORT | Serial output beat valid per port |
| wr_done | output | NPORT | Write-in commit pulse per port |

## Verification
Two things can coincide on one clock edge. One is a bind request taking a bank; the other is the host path storing into that same bank, or rejection logic judging a port that is mid-stream. The bench drives a read-out command and a host store to the same bank and row in a single cycle, then compares the streamed page with the newly stored one. It also fires bind requests at engaged banks and ports while other ports are streaming and shifting in. It then judges the outcome from the error pulse and from the untouched timing and content of the streams already running, with expected pages computed arithmetically from bank, row and a seed.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_LOAD   = 3'd1,
    BK_SOUT   = 3'd2,
    BK_SIN    = 3'd3,
    BK_COMMIT = 3'd4
  } bk_mode_e;
endpackage

// File: rtl/spx_admit.sv
// Command admission: range and occupancy checks, one-hot bank start.
module spx_admit #(
  parameter int NBANK  = 32,
  parameter int NPORT  = 4,
  parameter int ROWS   = 4,
  parameter int BANK_W = 5,
  parameter int PORT_W = 2,
  parameter int ROW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic              cmd_dir,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [NBANK-1:0]  bank_busy,
  input  logic [NPORT-1:0]  port_busy,
  output logic [NBANK-1:0]  start,
  output logic              go_dir,
  output logic [PORT_W-1:0] go_port,
  output logic [ROW_W-1:0]  go_row,
  output logic              cmd_ack,
  output logic              cmd_err
);
  logic in_range, bank_taken, port_taken, bank_ok, port_ok, accept;

  always_comb begin
    bank_taken = 1'b0;
    bank_ok    = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (cmd_bank == BANK_W'(b)) begin
        bank_ok    = 1'b1;
        bank_taken = bank_busy[b];
      end
    end
    port_taken = 1'b0;
    port_ok    = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (cmd_port == PORT_W'(p)) begin
        port_ok    = 1'b1;
        port_taken = port_busy[p];
      end
    end
    in_range = bank_ok && port_ok && (int'(cmd_row) < ROWS);
    accept   = cmd_vld && in_range && !bank_taken && !port_taken;
    for (int b = 0; b < NBANK; b++) begin
      start[b] = accept && (cmd_bank == BANK_W'(b));
    end
  end

  assign go_dir  = cmd_dir;
  assign go_port = cmd_port;
  assign go_row  = cmd_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_ack <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_ack <= accept;
      cmd_err <= cmd_vld && !accept;
    end
  end

  // R4: a request is answered by exactly one of the two flags
  p_ack_err_excl_r4 : assert property (@(posedge clk) disable iff (rst)
    !(cmd_ack && cmd_err));

  // R4: every answer stems from a request on the previous edge
  p_answer_needs_req_r4 : assert property (@(posedge clk) disable iff (rst)
    (cmd_ack || cmd_err) |-> $past(cmd_vld));
endmodule

// File: rtl/spx_bank.sv
// One bank: page-row array, page shift register and transfer sequencer.
module spx_bank
  import spx_pkg::*;
#(
  parameter int PAGE_W = 1024,
  parameter int LANE_W = 1,
  parameter int ROWS   = 4,
  parameter int NPORT  = 4,
  parameter int PORT_W = 2,
  parameter int ROW_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    go_dir,
  input  logic [PORT_W-1:0]       go_port,
  input  logic [ROW_W-1:0]        go_row,
  input  logic [NPORT*LANE_W-1:0] lane_in,
  input  logic [NPORT-1:0]        lane_vld,
  input  logic                    hw_en,
  input  logic [ROW_W-1:0]        hw_row,
  input  logic [PAGE_W-1:0]       hw_data,
  input  logic                    hr_en,
  input  logic [ROW_W-1:0]        hr_row,
  output logic [PAGE_W-1:0]       rd_q,
  output bk_mode_e                mode,
  output logic [PORT_W-1:0]       port_q,
  output logic [LANE_W-1:0]       top
);
  localparam int BEATS = PAGE_W / LANE_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [PAGE_W-1:0] mem [ROWS];
  logic [PAGE_W-1:0] sreg;
  logic [ROW_W-1:0]  row_q;
  logic [CNT_W-1:0]  cnt;
  logic [LANE_W-1:0] lane;
  logic              lvld;

  // crossbar input side: pick the lane of the bound port
  always_comb begin
    lane = '0;
    lvld = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (port_q == PORT_W'(p)) begin
        lane = lane_in[p*LANE_W +: LANE_W];
        lvld = lane_vld[p];
      end
    end
  end

  // storage and page register: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (mode == BK_COMMIT) begin
      mem[row_q] <= sreg;
    end else if (hw_en && mode == BK_IDLE) begin
      mem[hw_row] <= hw_data;
    end
    if (hr_en) begin
      rd_q <= mem[hr_row];
    end
    case (mode)
      BK_LOAD: sreg <= mem[row_q];
      BK_SOUT: sreg <= sreg << LANE_W;
      BK_SIN:  if (lvld) sreg <= {sreg[PAGE_W-LANE_W-1:0], lane};
      default: ;
    endcase
  end

  // transfer sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= BK_IDLE;
      port_q <= '0;
      row_q  <= '0;
      cnt    <= '0;
    end else begin
      case (mode)
        BK_IDLE: begin
          if (start) begin
            mode   <= go_dir ? BK_SIN : BK_LOAD;
            port_q <= go_port;
            row_q  <= go_row;
            cnt    <= '0;
          end
        end
        BK_LOAD: begin
          mode <= BK_SOUT;
          cnt  <= '0;
        end
        BK_SOUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) mode <= BK_IDLE;
        end
        BK_SIN: begin
          if (lvld) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) mode <= BK_COMMIT;
          end
        end
        BK_COMMIT: mode <= BK_IDLE;
        default:   mode <= BK_IDLE;
      endcase
    end
  end

  assign top = sreg[PAGE_W-1 -: LANE_W];

  // R2: a started stream keeps going every cycle until its last beat
  p_no_stall_r2 : assert property (@(posedge clk) disable iff (rst)
    (mode == BK_SOUT && cnt != LAST) |=> mode == BK_SOUT);

  // R2: streaming is always preceded by the parallel page load
  p_load_first_r2 : assert property (@(posedge clk) disable iff (rst)
    $rose(mode == BK_SOUT) |-> $past(mode) == BK_LOAD);

  // R3: commit lasts a single cycle
  p_commit_once_r3 : assert property (@(posedge clk) disable iff (rst)
    mode == BK_COMMIT |=> mode == BK_IDLE);

  // R4: admission never starts a bank that is engaged
  p_start_idle_r4 : assert property (@(posedge clk) disable iff (rst)
    start |-> mode == BK_IDLE);

  // R4: the bound port does not change during a transfer
  p_port_stable_r4 : assert property (@(posedge clk) disable iff (rst)
    (mode != BK_IDLE && $past(mode) != BK_IDLE) |-> $stable(port_q));
endmodule

// File: rtl/spx_port.sv
// One serial port: crossbar output side and registered lane/valid/done.
module spx_port
  import spx_pkg::*;
#(
  parameter int NBANK   = 32,
  parameter int LANE_W  = 1,
  parameter int PORT_W  = 2,
  parameter int PORT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  bk_mode_e          bank_mode [NBANK],
  input  logic [PORT_W-1:0] bank_port [NBANK],
  input  logic [LANE_W-1:0] bank_top  [NBANK],
  output logic              busy,
  output logic [LANE_W-1:0] out_data,
  output logic              out_vld,
  output logic              done
);
  logic              hit, streaming, committing;
  logic [LANE_W-1:0] chunk;
  int unsigned       nhit;

  always_comb begin
    hit        = 1'b0;
    streaming  = 1'b0;
    committing = 1'b0;
    chunk      = '0;
    nhit       = 0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_mode[b] != BK_IDLE && bank_port[b] == PORT_W'(PORT_ID)) begin
        hit  = 1'b1;
        nhit = nhit + 1;
        if (bank_mode[b] == BK_SOUT) begin
          streaming = 1'b1;
          chunk     = bank_top[b];
        end
        if (bank_mode[b] == BK_COMMIT) committing = 1'b1;
      end
    end
  end

  assign busy = hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      done     <= 1'b0;
    end else begin
      out_vld  <= streaming;
      out_data <= streaming ? chunk : '0;
      done     <= committing;
    end
  end

  // R9: the crossbar binds at most one bank to this port
  p_single_bind_r9 : assert property (@(posedge clk) disable iff (rst)
    nhit <= 1);

  // R6: an idle lane carries zero
  p_idle_quiet_r6 : assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> out_data == '0);

  // R3: the done flag is a single-cycle pulse
  p_done_pulse_r3 : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: a port never streams and commits in the same cycle
  p_vld_done_excl_r5 : assert property (@(posedge clk) disable iff (rst)
    !(out_vld && done));
endmodule

// File: rtl/serial_page_xbar.sv
module serial_page_xbar
  import spx_pkg::*;
#(
  parameter int NBANK  = 32,
  parameter int PAGE_W = 1024,
  parameter int LANE_W = 1,
  parameter int NPORT  = 4,
  parameter int ROWS   = 4,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_vld,
  input  logic                    cmd_dir,
  input  logic [BANK_W-1:0]       cmd_bank,
  input  logic [PORT_W-1:0]       cmd_port,
  input  logic [ROW_W-1:0]        cmd_row,
  output logic                    cmd_ack,
  output logic                    cmd_err,
  input  logic                    pg_wr,
  input  logic                    pg_rd,
  input  logic [BANK_W-1:0]       pg_bank,
  input  logic [ROW_W-1:0]        pg_row,
  input  logic [PAGE_W-1:0]       pg_wdata,
  output logic [PAGE_W-1:0]       pg_rdata,
  input  logic [NPORT*LANE_W-1:0] sin_data,
  input  logic [NPORT-1:0]        sin_vld,
  output logic [NPORT*LANE_W-1:0] sout_data,
  output logic [NPORT-1:0]        sout_vld,
  output logic [NPORT-1:0]        wr_done
);
  bk_mode_e          bank_mode [NBANK];
  logic [PORT_W-1:0] bank_port [NBANK];
  logic [LANE_W-1:0] bank_top  [NBANK];
  logic [PAGE_W-1:0] bank_rd   [NBANK];
  logic [NBANK-1:0]  bank_busy, start;
  logic [NPORT-1:0]  port_busy;
  logic              go_dir;
  logic [PORT_W-1:0] go_port;
  logic [ROW_W-1:0]  go_row;
  logic [BANK_W-1:0] rd_bank_q;

  spx_admit #(
    .NBANK(NBANK), .NPORT(NPORT), .ROWS(ROWS),
    .BANK_W(BANK_W), .PORT_W(PORT_W), .ROW_W(ROW_W)
  ) u_admit (
    .clk(clk), .rst(rst),
    .cmd_vld(cmd_vld), .cmd_dir(cmd_dir), .cmd_bank(cmd_bank),
    .cmd_port(cmd_port), .cmd_row(cmd_row),
    .bank_busy(bank_busy), .port_busy(port_busy),
    .start(start), .go_dir(go_dir), .go_port(go_port), .go_row(go_row),
    .cmd_ack(cmd_ack), .cmd_err(cmd_err)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hw_en, hr_en;
    assign hw_en = pg_wr && (pg_bank == BANK_W'(b));
    assign hr_en = pg_rd && (pg_bank == BANK_W'(b));
    assign bank_busy[b] = (bank_mode[b] != BK_IDLE);

    spx_bank #(
      .PAGE_W(PAGE_W), .LANE_W(LANE_W), .ROWS(ROWS),
      .NPORT(NPORT), .PORT_W(PORT_W), .ROW_W(ROW_W)
    ) u_bank (
      .clk(clk), .rst(rst),
      .start(start[b]), .go_dir(go_dir), .go_port(go_port), .go_row(go_row),
      .lane_in(sin_data), .lane_vld(sin_vld),
      .hw_en(hw_en), .hw_row(pg_row), .hw_data(pg_wdata),
      .hr_en(hr_en), .hr_row(pg_row), .rd_q(bank_rd[b]),
      .mode(bank_mode[b]), .port_q(bank_port[b]), .top(bank_top[b])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    spx_port #(
      .NBANK(NBANK), .LANE_W(LANE_W), .PORT_W(PORT_W), .PORT_ID(p)
    ) u_port (
      .clk(clk), .rst(rst),
      .bank_mode(bank_mode), .bank_port(bank_port), .bank_top(bank_top),
      .busy(port_busy[p]),
      .out_data(sout_data[p*LANE_W +: LANE_W]),
      .out_vld(sout_vld[p]),
      .done(wr_done[p])
    );
  end

  // host fetch: remember which bank answers, select its read register
  always_ff @(posedge clk) begin
    if (rst) rd_bank_q <= '0;
    else if (pg_rd) rd_bank_q <= pg_bank;
  end

  always_comb begin
    pg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rd_bank_q == BANK_W'(b)) pg_rdata = bank_rd[b];
    end
  end
endmodule

// File: tb/serial_page_xbar_bench.sv
module serial_page_xbar_bench;
  localparam int NB = 4, PW = 16, LW = 2, NP = 3, RW = 2;
  localparam int BEATS = PW / LW;
  localparam int BW = 2, PTW = 2, RWW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_vld = 0, cmd_dir = 0;
  logic [BW-1:0] cmd_bank = '0, pg_bank = '0;
  logic [PTW-1:0] cmd_port = '0;
  logic [RWW-1:0] cmd_row = '0, pg_row = '0;
  logic cmd_ack, cmd_err, pg_wr = 0, pg_rd = 0;
  logic [PW-1:0] pg_wdata = '0, pg_rdata;
  logic [NP*LW-1:0] sin_data = '0, sout_data;
  logic [NP-1:0] sin_vld = '0, sout_vld, wr_done;

  always #5 clk = ~clk;

  serial_page_xbar #(.NBANK(NB), .PAGE_W(PW), .LANE_W(LW), .NPORT(NP), .ROWS(RW))
  u_serial_page_xbar (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_dir(cmd_dir), .cmd_bank(cmd_bank),
    .cmd_port(cmd_port), .cmd_row(cmd_row), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
    .pg_wr(pg_wr), .pg_rd(pg_rd), .pg_bank(pg_bank), .pg_row(pg_row),
    .pg_wdata(pg_wdata), .pg_rdata(pg_rdata), .sin_data(sin_data), .sin_vld(sin_vld),
    .sout_data(sout_data), .sout_vld(sout_vld), .wr_done(wr_done)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [PW-1:0] model [NB][RW];

  // output monitor at the falling edge
  logic [PW-1:0] cap [NP];
  int nb [NP], first [NP], last [NP], dcnt [NP], dcyc [NP];
  bit quiet_bad [NP];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (sout_vld[p]) begin
        cap[p] = {cap[p][PW-LW-1:0], sout_data[p*LW +: LW]};
        if (nb[p] == 0) first[p] = cyc;
        last[p] = cyc;
        nb[p]++;
      end else if (sout_data[p*LW +: LW] != '0) begin
        quiet_bad[p] = 1'b1;
      end
      if (wr_done[p]) begin
        dcnt[p]++;
        dcyc[p] = cyc;
      end
    end
  end

  function automatic logic [PW-1:0] pat(int b, int r, int s);
    return PW'((b * 4919 + r * 9320 + s * 3855 + 7) ^ 42435);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    for (int p = 0; p < NP; p++) begin
      cap[p] = '0; nb[p] = 0; first[p] = -1; last[p] = -1;
      dcnt[p] = 0; dcyc[p] = -1;
    end
  endtask

  task automatic issue(input bit d, input int b, input int p, input int r,
                       output int n, output bit ack, output bit err);
    cmd_vld = 1; cmd_dir = d; cmd_bank = BW'(b); cmd_port = PTW'(p); cmd_row = RWW'(r);
    tick();
    n = cyc; ack = cmd_ack; err = cmd_err;
    cmd_vld = 0;
  endtask

  task automatic hwrite(input int b, input int r, input logic [PW-1:0] d);
    pg_wr = 1; pg_bank = BW'(b); pg_row = RWW'(r); pg_wdata = d;
    tick();
    pg_wr = 0;
  endtask

  task automatic hread(input int b, input int r, output logic [PW-1:0] d);
    pg_rd = 1; pg_bank = BW'(b); pg_row = RWW'(r);
    tick();
    pg_rd = 0;
    d = pg_rdata;
  endtask

  // shift a page into port p; gap inserts idle cycles; x = edge of last beat
  task automatic sdrive(input int p, input logic [PW-1:0] pg, input bit gap, output int x);
    for (int k = 0; k < BEATS; k++) begin
      if (gap && (k % 3 == 1)) begin
        sin_vld[p] = 0;
        sin_data[p*LW +: LW] = 2'b11;
        tick();
      end
      sin_data[p*LW +: LW] = pg[PW-1-k*LW -: LW];
      sin_vld[p] = 1;
      tick();
    end
    x = cyc;
    sin_vld[p] = 0;
    sin_data[p*LW +: LW] = '0;
  endtask

  task automatic wait_n(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    summary();
  end

  initial begin
    int n, n0, n1, n2, x;
    bit ack, err;
    logic [PW-1:0] d, np;
    clr();
    for (int p = 0; p < NP; p++) quiet_bad[p] = 0;
    wait_n(3);
    rst = 0;
    // R1 reset state
    check(!cmd_ack && !cmd_err && sout_vld == 0 && sout_data == 0 && wr_done == 0,
          "R1 reset outputs", {cmd_ack, cmd_err, sout_vld, sout_data, wr_done}, 0);

    // R7 host fill and fetch
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < RW; r++) begin
        model[b][r] = pat(b, r, 0);
        hwrite(b, r, model[b][r]);
      end
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < RW; r++) begin
        hread(b, r, d);
        check(d == model[b][r], "R7 host fetch", d, model[b][r]);
      end

    // R2 / R9 read-out over every bank and port
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) begin
        clr();
        issue(0, b, p, (b + p) % RW, n, ack, err);
        check(ack && !err, "R2 read accepted", {ack, err}, 2'b10);
        wait_n(BEATS + 4);
        check(cap[p] == model[b][(b + p) % RW] && nb[p] == BEATS, "R2 R9 page content",
              cap[p], model[b][(b + p) % RW]);
        check(first[p] == n + 2 && last[p] == n + 1 + BEATS, "R2 beat timing",
              first[p], n + 2);
        check(nb[(p + 1) % NP] == 0 && nb[(p + 2) % NP] == 0, "R9 other ports silent",
              nb[(p + 1) % NP] + nb[(p + 2) % NP], 0);
      end
    // R6 idle lanes stayed zero
    check(!quiet_bad[0] && !quiet_bad[1] && !quiet_bad[2], "R6 idle lane zero",
          {quiet_bad[0], quiet_bad[1], quiet_bad[2]}, 0);

    // R3 write-in with and without gaps
    for (int b = 0; b < NB; b++) begin
      int p;
      p = (b + 1) % NP;
      clr();
      np = pat(b, 0, 5);
      issue(1, b, p, 0, n, ack, err);
      check(ack && !err, "R3 write accepted", {ack, err}, 2'b10);
      sdrive(p, np, b[0], x);
      wait_n(3);
      check(dcnt[p] == 1 && dcyc[p] == x + 1, "R3 done pulse", dcyc[p], x + 1);
      check(nb[p] == 0, "R3 no output during write", nb[p], 0);
      model[b][0] = np;
      hread(b, 0, d);
      check(d == np, "R3 committed page", d, np);
    end

    // R5 two read-outs and a write-in at once
    clr();
    issue(0, 0, 0, 1, n0, ack, err);
    issue(0, 1, 1, 0, n1, ack, err);
    np = pat(2, 1, 9);
    issue(1, 2, 2, 1, n2, ack, err);
    sdrive(2, np, 0, x);
    wait_n(4);
    check(cap[0] == model[0][1] && first[0] == n0 + 2 && nb[0] == BEATS,
          "R5 port0 stream", cap[0], model[0][1]);
    check(cap[1] == model[1][0] && first[1] == n1 + 2 && nb[1] == BEATS,
          "R5 port1 stream", cap[1], model[1][0]);
    check(dcnt[2] == 1 && dcyc[2] == x + 1, "R5 port2 done", dcyc[2], x + 1);
    model[2][1] = np;
    hread(2, 1, d);
    check(d == np, "R5 port2 page", d, np);

    // R4 rejections while a stream runs
    clr();
    issue(0, 3, 0, 0, n, ack, err);
    check(ack && !err, "R4 first bind", {ack, err}, 2'b10);
    issue(0, 3, 1, 0, n1, ack, err);
    check(!ack && err, "R4 busy bank", {ack, err}, 2'b01);
    issue(0, 0, 0, 0, n1, ack, err);
    check(!ack && err, "R4 busy port", {ack, err}, 2'b01);
    issue(1, 1, 0, 0, n1, ack, err);
    check(!ack && err, "R4 busy port write", {ack, err}, 2'b01);
    wait_n(BEATS + 4);
    check(cap[0] == model[3][0] && nb[0] == BEATS && first[0] == n + 2 && nb[1] == 0,
          "R4 stream undisturbed", cap[0], model[3][0]);

    // R8 host store to an engaged bank is dropped
    clr();
    np = pat(1, 0, 12);
    issue(1, 1, 1, 0, n, ack, err);
    hwrite(1, 1, 16'hDEAD);
    hwrite(1, 0, 16'hBEEF);
    sdrive(1, np, 1, x);
    wait_n(3);
    model[1][0] = np;
    hread(1, 1, d);
    check(d == model[1][1], "R8 other row kept", d, model[1][1]);
    hread(1, 0, d);
    check(d == np, "R8 transfer row from stream", d, np);

    // R10 out-of-range port index
    clr();
    issue(0, 1, 3, 0, n, ack, err);
    check(!ack && err, "R10 bad port", {ack, err}, 2'b01);
    wait_n(BEATS + 4);
    check(nb[0] == 0 && nb[1] == 0 && nb[2] == 0, "R10 nothing started",
          nb[0] + nb[1] + nb[2], 0);

    // R7 / R2 host store and bind in the same cycle
    clr();
    np = pat(2, 0, 21);
    pg_wr = 1; pg_bank = 2'd2; pg_row = 1'b0; pg_wdata = np;
    issue(0, 2, 1, 0, n, ack, err);
    pg_wr = 0;
    wait_n(BEATS + 4);
    check(ack && cap[1] == np && nb[1] == BEATS && first[1] == n + 2,
          "R7 same-cycle store then stream", cap[1], np);
    check(!quiet_bad[0] && !quiet_bad[1] && !quiet_bad[2], "R6 idle lane zero end",
          {quiet_bad[0], quiet_bad[1], quiet_bad[2]}, 0);
    summary();
  end
endmodule